// File: doc/BRIEF.md
# Single-Wire Bus Slot and Reset Sequencer

This block produces the time slots of an open-drain single-wire bus. A host selects an operation on `op_i`, picks normal or overdrive timing on `od_i` and pulses `start_i`. The block then drives `pull_o` to hold the line low for the length the operation needs. It watches a synchronized copy of `line_i` and, when the operation is over, gives a one-cycle `done_o` together with a held `result_o` bit.

Time is counted in ticks. A tick lasts `CLKS_PER_US` clock cycles in normal mode. In overdrive it lasts `CLKS_PER_US/OD_DIV` cycles, with a floor of one cycle. All durations below are in ticks, so overdrive shortens every one of them by the same factor.

A bus reset has several parts. The block drives a long low pulse and then waits for the line to rise. If the line stays low for too long, the block reports a short. Otherwise it watches for a presence pulse from a device. It keeps the engine busy until the bus has had its recovery time. That time is a floor counted from the start of the operation, plus three times the measured presence delay counted from the end of the pulse.

Top module: `ow_slot_engine`

## Requirements
- R1: While idle, a high `start_i` at a clock edge is accepted. From the next cycle `busy_o` and `pull_o` are high. `pull_o` is never high while `busy_o` is low.
- R2: A tick is `CLKS_PER_US` cycles when `od_i` was 0 at acceptance, and `CLKS_PER_US/OD_DIV` cycles (at least 1) when it was 1. Every duration is counted in ticks.
- R3: `op_i` = 2'b00 is a write-0 slot. `pull_o` stays high for 60 ticks from acceptance and the sampled result is 0.
- R4: `op_i` = 2'b01 is a write-1 or read slot. `pull_o` is high for 2 ticks. `result_o` is the synchronized line level sampled at tick 15.
- R5: A slot ends at tick 65, which is no earlier than tick 60. At that edge `busy_o` falls and `done_o` is high for exactly one cycle.
- R6: `op_i[1]` = 1 is a bus reset. `pull_o` is high for exactly 480 ticks.
- R7: After the reset pulse, the engine waits for the line to go high until tick 4320. If the line is still low at that tick, the reset ends there with `result_o` = 1 and `short_o` = 1. `short_o` is 0 after every other operation.
- R8: After the line rises, a fall seen within 60 ticks counts as presence, and the reset result is 0. If no fall is seen in that window, the result is 1.
- R9: A reset never completes before tick 960.
- R10: When a presence pulse ends at tick E, with delay D from rise to fall, the reset does not complete before tick E + 3·D.
- R11: `start_i` while busy is ignored. Changes to `op_i` and `od_i` during an operation do not alter its timing or result.
- R12: Out of reset, `result_o` = 1 and `short_o` = 0. Both hold their values from one `done_o` to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_i | input | 2 | 00 write-0, 01 write-1/read, 1x bus reset |
| od_i | input | 1 | 1 selects overdrive timing |
| line_i | input | 1 | Raw bus level |
| pull_o | output | 1 | 1 drives the bus low |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 1 | Sampled bit, or 0 when presence was detected |
| short_o | output | 1 | Reset ended on a stuck-low line |

## Verification
Take L as the tick length in cycles and the acceptance edge as cycle 0. `pull_o` drops exactly at edge span·L and `busy_o`/`done_o` change exactly at edge D·L, where D is the completion tick. `result_o` and `short_o` take their new values at that same edge. The reference model works out D for each stimulus. The bench compares all five outputs on the falling clock edge after every rising edge. The bench moves the simulated device's pull only on the falling edge that follows a tick edge. Line decisions happen only on ticks and the line passes through two synchronizer stages, so each device change is seen at the next tick. This holds for any tick length of at least three cycles, so the expected completion tick stays exact.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RLOW,
    ST_RWAIT,
    ST_RPRES,
    ST_RPLOW,
    ST_RRECOV
  } ow_state_e;

  localparam int SLOT_FLOOR = 60;  // no slot may finish earlier
endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int CLKS_NORM = 100,
  parameter int CLKS_OD   = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic od_i,
  output logic tick_o
);
  localparam int CW = (CLKS_NORM > 1) ? $clog2(CLKS_NORM + 1) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          wrap;

  assign lim    = od_i ? CW'(CLKS_OD) : CW'(CLKS_NORM);
  assign wrap   = (cnt_q == lim - CW'(1));
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (wrap)         cnt_q <= '0;
    else                   cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < lim); // R2
endmodule

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= line_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  assign line_o = sync_q[STAGES-1];
endmodule

// File: rtl/ow_seq.sv
module ow_seq
  import ow_pkg::*;
#(
  parameter int T_SLOT    = 65,
  parameter int T_W0_LOW  = 60,
  parameter int T_W1_LOW  = 2,
  parameter int T_SAMPLE  = 15,
  parameter int T_RST_LOW = 480,
  parameter int T_RST_MIN = 960,
  parameter int T_PDH_MAX = 60,
  parameter int T_STUCK   = 3840
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic       od_i,
  input  logic       tick_i,
  input  logic       line_i,
  output logic       od_o,
  output logic       busy_o,
  output logic       pull_o,
  output logic       done_o,
  output logic       result_o,
  output logic       short_o
);
  localparam int T_CAP  = T_RST_LOW + T_STUCK;
  localparam int T_TMAX = T_CAP + 4 * T_PDH_MAX + 2;
  localparam int TW     = $clog2(T_TMAX + 1);
  localparam int EW     = TW + 2;

  localparam logic [TW-1:0] K_SLOT   = TW'(T_SLOT);
  localparam logic [TW-1:0] K_W0     = TW'(T_W0_LOW);
  localparam logic [TW-1:0] K_W1     = TW'(T_W1_LOW);
  localparam logic [TW-1:0] K_SAMPLE = TW'(T_SAMPLE);
  localparam logic [TW-1:0] K_RLOW   = TW'(T_RST_LOW);
  localparam logic [TW-1:0] K_PDH    = TW'(T_PDH_MAX);
  localparam logic [TW-1:0] K_CAP    = TW'(T_CAP);
  localparam logic [EW-1:0] K_RMIN   = EW'(T_RST_MIN);

  ow_state_e     state_q;
  logic [TW-1:0] t_q, t_nx, mark_q, fall_q, dly;
  logic [EW-1:0] end_q, nx_ext, floor_nx, recov_cand, recov_end;
  logic          rst_op_q, w1_q, od_q, smp_q, pres_q, done_q, res_q, short_q;
  logic [TW-1:0] low_len;

  assign t_nx       = t_q + TW'(1);
  assign nx_ext     = {2'b00, t_nx};
  assign dly        = fall_q - mark_q;
  assign recov_cand = nx_ext + {2'b00, dly} + {1'b0, dly, 1'b0};
  assign floor_nx   = (nx_ext > K_RMIN) ? nx_ext : K_RMIN;
  assign recov_end  = (recov_cand > K_RMIN) ? recov_cand : K_RMIN;
  assign low_len    = w1_q ? K_W1 : K_W0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      t_q      <= '0;
      mark_q   <= '0;
      fall_q   <= '0;
      end_q    <= '0;
      rst_op_q <= 1'b0;
      w1_q     <= 1'b0;
      od_q     <= 1'b0;
      smp_q    <= 1'b1;
      pres_q   <= 1'b0;
      done_q   <= 1'b0;
      res_q    <= 1'b1;
      short_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          rst_op_q <= op_i[1];
          w1_q     <= op_i[0];
          od_q     <= od_i;
          t_q      <= '0;
          pres_q   <= 1'b0;
          state_q  <= op_i[1] ? ST_RLOW : ST_SLOT;
        end
      end else if (tick_i) begin
        t_q <= t_nx;
        case (state_q)
          ST_SLOT: begin
            if (t_nx == K_SAMPLE) smp_q <= line_i;
            if (t_nx == K_SLOT) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              res_q   <= smp_q;
              short_q <= 1'b0;
            end
          end
          ST_RLOW: if (t_nx == K_RLOW) state_q <= ST_RWAIT;
          ST_RWAIT: begin
            if (line_i) begin
              mark_q  <= t_nx;
              state_q <= ST_RPRES;
            end else if (t_nx == K_CAP) begin  // line stuck low: short
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              res_q   <= 1'b1;
              short_q <= 1'b1;
            end
          end
          ST_RPRES: begin
            if (!line_i) begin
              fall_q  <= t_nx;
              pres_q  <= 1'b1;
              state_q <= ST_RPLOW;
            end else if (t_nx - mark_q >= K_PDH) begin
              end_q   <= floor_nx;
              state_q <= ST_RRECOV;
            end
          end
          ST_RPLOW: begin
            if (line_i) begin
              end_q   <= recov_end;
              state_q <= ST_RRECOV;
            end else if (t_nx == K_CAP) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              res_q   <= 1'b0;
              short_q <= 1'b0;
            end
          end
          ST_RRECOV: begin
            if (nx_ext >= end_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              res_q   <= ~pres_q;
              short_q <= 1'b0;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign pull_o   = (state_q == ST_RLOW) || ((state_q == ST_SLOT) && (t_q < low_len));
  assign done_o   = done_q;
  assign result_o = res_q;
  assign short_o  = short_q;
  assign od_o     = od_q;

  AST_PULL_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_o |-> busy_o); // R1
  AST_DONE_CLOSES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R5
  AST_SLOT_MIN_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !rst_op_q) |-> t_q >= TW'(SLOT_FLOOR)); // R5
  AST_RST_LOW_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pull_o) && rst_op_q) |-> t_q == K_RLOW); // R6
  AST_RST_MIN_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && rst_op_q) |-> {2'b00, t_q} >= K_RMIN); // R9
  AST_SHORT_IMPLIES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |-> result_o); // R7
  AST_OP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(rst_op_q) && $stable(od_q) && $stable(w1_q))); // R11
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(short_o))); // R12
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine #(
  parameter int CLKS_PER_US = 100,
  parameter int OD_DIV      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int T_SLOT      = 65,
  parameter int T_W0_LOW    = 60,
  parameter int T_W1_LOW    = 2,
  parameter int T_SAMPLE    = 15,
  parameter int T_RST_LOW   = 480,
  parameter int T_RST_MIN   = 960,
  parameter int T_PDH_MAX   = 60,
  parameter int T_STUCK     = 3840
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic       od_i,
  input  logic       line_i,
  output logic       pull_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       result_o,
  output logic       short_o
);
  localparam int CLKS_OD = (CLKS_PER_US >= OD_DIV) ? CLKS_PER_US / OD_DIV : 1;

  logic line_s, tick, od_act, busy;

  ow_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_i),
    .line_o(line_s)
  );

  ow_tick_gen #(.CLKS_NORM(CLKS_PER_US), .CLKS_OD(CLKS_OD)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .od_i  (od_act),
    .tick_o(tick)
  );

  ow_seq #(
    .T_SLOT   (T_SLOT),
    .T_W0_LOW (T_W0_LOW),
    .T_W1_LOW (T_W1_LOW),
    .T_SAMPLE (T_SAMPLE),
    .T_RST_LOW(T_RST_LOW),
    .T_RST_MIN(T_RST_MIN),
    .T_PDH_MAX(T_PDH_MAX),
    .T_STUCK  (T_STUCK)
  ) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op_i),
    .od_i    (od_i),
    .tick_i  (tick),
    .line_i  (line_s),
    .od_o    (od_act),
    .busy_o  (busy),
    .pull_o  (pull_o),
    .done_o  (done_o),
    .result_o(result_o),
    .short_o (short_o)
  );

  assign busy_o = busy;
endmodule

// File: tb/test_ow_slot_engine.sv
module test_ow_slot_engine;
  localparam int LN = 12;
  localparam int ODIV = 4;
  localparam int LO = LN / ODIV;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic od_i = 1'b0;
  logic line;
  logic dev_pull = 1'b0;
  logic pull_o, busy_o, done_o, result_o, short_o;

  int checks = 0;
  int errs = 0;
  int hold_r = 1;
  int hold_s = 0;
  int m_rst, m_low, m_a, m_b;

  always #5 clk = ~clk;

  always_comb line = ~(pull_o | dev_pull);

  ow_slot_engine #(.CLKS_PER_US(LN), .OD_DIV(ODIV)) i_ow_slot_engine (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .od_i(od_i),
    .line_i(line), .pull_o(pull_o), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .short_o(short_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // bus level as seen at the tick edge that makes the tick count k
  function automatic bit seen(int k);
    bit own = m_rst ? (k <= 480) : (k <= m_low);
    bit dev = (k > m_a) && (k <= m_b);
    return !(own || dev);
  endfunction

  task automatic model(output int d, output int r, output int s);
    int ph = 0, rise = 0, fall = 0, en = 0, pres = 0;
    bit fin = 0;
    s = 0; r = 1; d = 0;
    if (!m_rst) begin
      d = 65;
      r = seen(15) ? 1 : 0;
    end else begin
      for (int k = 481; !fin; k++) begin
        case (ph)
          0: if (seen(k)) begin rise = k; ph = 1; end
             else if (k == 4320) begin fin = 1; d = k; r = 1; s = 1; end
          1: if (!seen(k)) begin fall = k; pres = 1; ph = 2; end
             else if (k - rise >= 60) begin en = (k > 960) ? k : 960; ph = 3; end
          2: if (seen(k)) begin
               en = k + 3 * (fall - rise);
               if (en < 960) en = 960;
               ph = 3;
             end else if (k == 4320) begin fin = 1; d = k; r = 0; end
          default: if (k >= en) begin fin = 1; d = k; r = pres ? 0 : 1; end
        endcase
      end
    end
  endtask

  task automatic run_op(input bit is_rst, input bit w1, input bit od, input int a, input int b,
                        input bit inject, input string tp, input string tb, input string tr);
    int d, r, s, l, span;
    m_rst = is_rst; m_low = w1 ? 2 : 60; m_a = a; m_b = b;
    model(d, r, s);
    l = od ? LO : LN;
    span = is_rst ? 480 : m_low;
    @(negedge clk);
    op_i = {is_rst, w1}; od_i = od; start_i = 1'b1;
    @(posedge clk);
    for (int n = 0; n <= d * l + 1; n++) begin
      @(negedge clk);
      if (n == 0) start_i = 1'b0;
      chk(tp, "pull", int'(pull_o), int'(n < span * l));
      chk(tb, "busy", int'(busy_o), int'(n < d * l));
      chk(tb, "done", int'(done_o), int'(n == d * l));
      chk((n >= d * l) ? tr : "R12", "result", int'(result_o), (n >= d * l) ? r : hold_r);
      chk((n >= d * l) ? "R7" : "R12", "short", int'(short_o), (n >= d * l) ? s : hold_s);
      dev_pull = ((n / l) >= a) && ((n / l) < b);
      if (inject && n == 2 * l) begin start_i = 1'b1; op_i = ~op_i; od_i = ~od; end
      if (inject && n == 2 * l + 1) start_i = 1'b0;
    end
    dev_pull = 1'b0;
    hold_r = r; hold_s = s;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    chk("R12", "reset result", int'(result_o), 1);
    chk("R12", "reset short", int'(short_o), 0);
    chk("R1", "reset busy", int'(busy_o), 0);
    chk("R1", "reset pull", int'(pull_o), 0);
    chk("R1", "reset done", int'(done_o), 0);
    // slots, normal timing
    run_op(0, 0, 0, 0, 0, 0, "R3", "R5", "R3");
    run_op(0, 1, 0, 0, 0, 0, "R4", "R5", "R4");
    run_op(0, 1, 0, 1, 30, 0, "R4", "R5", "R4");
    // overdrive slot with stray start and mode flip mid-slot
    run_op(0, 1, 1, 0, 0, 1, "R2", "R11", "R4");
    run_op(0, 0, 1, 0, 0, 0, "R2", "R5", "R3");
    // resets
    run_op(1, 0, 0, 510, 630, 0, "R6", "R9", "R8");
    run_op(1, 0, 0, 0, 0, 0, "R6", "R9", "R8");
    run_op(1, 0, 0, 540, 780, 0, "R6", "R10", "R8");
    run_op(1, 0, 0, 400, 100000, 0, "R6", "R7", "R7");
    run_op(1, 0, 0, 400, 1500, 0, "R6", "R7", "R8");
    run_op(1, 1, 1, 510, 630, 1, "R2", "R11", "R8");
    run_op(0, 1, 0, 0, 0, 0, "R4", "R5", "R4");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule